// File: doc/BRIEF.md
# Dual In-Order Issue Controller with Stack Region Disambiguation

This block sits between a decoded-instruction store and the execute stage of a stack-machine core. Each cycle the line supplies up to two consecutive decoded instructions. Each instruction carries four access flags, for reads and writes of the operand-stack area and of the local-variable area, together with an execution latency. The controller decides whether both instructions go out together or only the older one. Once a group has issued, it holds off further issue until the slowest member of that group has finished.

A mode input chooses how dependencies are checked. In merged mode the whole stack counts as one resource, so any stack write conflicts with any stack access by the partner. In split mode the area addressed from the operand-stack top and the area addressed from the local-variable base count as two independent resources. A write to one area then never blocks an access to the other. All outputs come straight from flip-flops, one cycle after the inputs they respond to.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Synchronous active-high reset clears `issue0`, `issue1` and `stall` to 0, and the block can issue on the first cycle after reset.
- R2: Flag encoding on `s0_acc`/`s1_acc` is bit0 operand-stack read, bit1 operand-stack write, bit2 local-variable read, bit3 local-variable write. Two instructions that only read issue together.
- R3: With `split_en`=0, any write by slot 0 to either area combined with any stack access by slot 1 (or the reverse) prevents pairing.
- R4: With `split_en`=1, a write in one area by one slot does not prevent pairing with an access of the other area by the other slot.
- R5: With `split_en`=1, a slot 0 write followed by a slot 1 read of the same area (read after write) prevents pairing.
- R6: With `split_en`=1, write-after-write and write-after-read within the same area prevent pairing.
- R7: `issue1` is only asserted together with `issue0`, and only when `v1` was 1.
- R8: When `v0` is 0, neither slot issues, whatever `v1` is.
- R9: After a group issues, `stall` is 1 for exactly L-1 cycles, starting in the issue cycle, where L is the largest latency in the group. A latency of 0 counts as 1.
- R10: While `stall` is 1, no issue occurs and the presented instructions are ignored.
- R11: When only slot 0 issues, only slot 0's latency sets the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_en | input | 1 | 1 = check the two stack areas separately, 0 = treat the stack as one resource |
| v0 | input | 1 | Slot 0 (older) instruction present |
| s0_acc | input | 4 | Slot 0 access flags |
| s0_lat | input | LAT_W | Slot 0 latency in cycles |
| v1 | input | 1 | Slot 1 (younger) instruction present |
| s1_acc | input | 4 | Slot 1 access flags |
| s1_lat | input | LAT_W | Slot 1 latency in cycles |
| issue0 | output | 1 | Slot 0 issued (registered) |
| issue1 | output | 1 | Slot 1 issued alongside slot 0 (registered) |
| stall | output | 1 | Issue blocked by an outstanding multi-cycle group (registered) |

## Verification
If the hazard check is wrong, `issue1` goes high or low on the wrong instruction pair. This shows up on the very next clock edge after that pair is presented, so each mode and each hazard type is exercised by its own single step. A corrupted stall counter shows up as `stall` deasserting too early or too late, or as `issue0` rising while `stall` is still high. The first of these is detected on the edge right after the issue cycle. Long-latency groups are followed by cycles with valid inputs so that an early release is visible.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef struct packed {
    logic lv_wr;  // bit3
    logic lv_rd;  // bit2
    logic os_wr;  // bit1
    logic os_rd;  // bit0
  } acc_t;

  localparam int NREG = 2;  // region 0: operand stack, region 1: local variables
endpackage

// File: rtl/dic_hazard.sv
module dic_hazard
  import dic_pkg::*;
(
  input  logic split_en,
  input  acc_t a0,
  input  acc_t a1,
  output logic conflict
);
  logic [NREG-1:0] rd0, wr0, rd1, wr1, hit;

  always_comb begin
    if (split_en) begin
      rd0 = {a0.lv_rd, a0.os_rd};
      wr0 = {a0.lv_wr, a0.os_wr};
      rd1 = {a1.lv_rd, a1.os_rd};
      wr1 = {a1.lv_wr, a1.os_wr};
    end else begin
      rd0 = {1'b0, a0.lv_rd | a0.os_rd};
      wr0 = {1'b0, a0.lv_wr | a0.os_wr};
      rd1 = {1'b0, a1.lv_rd | a1.os_rd};
      wr1 = {1'b0, a1.lv_wr | a1.os_wr};
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_region
    // RAW, WAW, WAR inside one resource
    assign hit[r] = (wr0[r] & rd1[r]) | (wr0[r] & wr1[r]) | (rd0[r] & wr1[r]);
  end

  assign conflict = |hit;
endmodule

// File: rtl/dic_lat_max.sv
module dic_lat_max #(
  parameter int LAT_W = 3
) (
  input  logic [LAT_W-1:0] la,
  input  logic [LAT_W-1:0] lb,
  input  logic             use_b,
  output logic [LAT_W-1:0] mx
);
  logic [LAT_W-1:0] ca, cb;

  assign ca = (la == '0) ? LAT_W'(1) : la;
  assign cb = (lb == '0) ? LAT_W'(1) : lb;
  assign mx = (use_b && (cb > ca)) ? cb : ca;
endmodule

// File: rtl/dic_stall_ctr.sv
module dic_stall_ctr #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             busy,
  output logic             stall_q
);
  logic [LAT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    if (load)             cnt_nxt = load_val;
    else if (cnt != '0)   cnt_nxt = cnt - LAT_W'(1);
    else                  cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stall_q <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      stall_q <= (cnt_nxt != '0);
    end
  end

  assign busy = (cnt != '0);

  // R9: a running count falls by one each cycle
  p_cnt_down_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - LAT_W'(1)));
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dic_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             split_en,
  input  logic             v0,
  input  logic [3:0]       s0_acc,
  input  logic [LAT_W-1:0] s0_lat,
  input  logic             v1,
  input  logic [3:0]       s1_acc,
  input  logic [LAT_W-1:0] s1_lat,
  output logic             issue0,
  output logic             issue1,
  output logic             stall
);
  logic             busy, conflict, go, pair;
  logic [LAT_W-1:0] mx;

  dic_hazard u_haz (
    .split_en (split_en),
    .a0       (acc_t'(s0_acc)),
    .a1       (acc_t'(s1_acc)),
    .conflict (conflict)
  );

  assign go   = v0 & ~busy;
  assign pair = go & v1 & ~conflict;

  dic_lat_max #(.LAT_W(LAT_W)) u_lmax (
    .la    (s0_lat),
    .lb    (s1_lat),
    .use_b (pair),
    .mx    (mx)
  );

  dic_stall_ctr #(.LAT_W(LAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .load_val (mx - LAT_W'(1)),
    .busy     (busy),
    .stall_q  (stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue0 <= 1'b0;
      issue1 <= 1'b0;
    end else begin
      issue0 <= go;
      issue1 <= pair;
    end
  end

  // R7: slot 1 never issues alone
  p_pair_needs_slot0_r7: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> issue0);
  // R7: slot 1 issue requires a present younger instruction
  p_pair_needs_v1_r7: assert property (@(posedge clk) disable iff (rst)
    v1 == 1'b0 |=> !issue1);
  // R10: no issue while stalled
  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> !issue0);
  // R8: no older instruction, no issue
  p_no_v0_no_issue_r8: assert property (@(posedge clk) disable iff (rst)
    !v0 |=> !issue0);
endmodule

// File: tb/dual_issue_ctrl_tb.sv
module dual_issue_ctrl_tb;
  localparam int LAT_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic split_en = 1'b0, v0 = 1'b0, v1 = 1'b0;
  logic [3:0] s0_acc = '0, s1_acc = '0;
  logic [LAT_W-1:0] s0_lat = '0, s1_lat = '0;
  logic issue0, issue1, stall;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  // flag encodings: bit0 os rd, bit1 os wr, bit2 lv rd, bit3 lv wr
  localparam logic [3:0] OSR = 4'b0001, OSW = 4'b0010, LVR = 4'b0100, LVW = 4'b1000;

  always #5 clk = ~clk;

  dual_issue_ctrl #(.LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst(rst), .split_en(split_en),
    .v0(v0), .s0_acc(s0_acc), .s0_lat(s0_lat),
    .v1(v1), .s1_acc(s1_acc), .s1_lat(s1_lat),
    .issue0(issue0), .issue1(issue1), .stall(stall)
  );

  task automatic step(input logic sp, input logic a, input logic [3:0] f0,
                      input logic [LAT_W-1:0] l0, input logic b, input logic [3:0] f1,
                      input logic [LAT_W-1:0] l1, input logic e0, input logic e1,
                      input logic es, input string tag);
    @(negedge clk);
    split_en = sp; v0 = a; s0_acc = f0; s0_lat = l0;
    v1 = b; s1_acc = f1; s1_lat = l1;
    exp_q.push_back({e0, e1, es});
    tag_q.push_back(tag);
  endtask

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({issue0, issue1, stall} !== e) begin
        fails++;
        $display("FAIL %s: got i0/i1/st=%b expected %b", t, {issue0, issue1, stall}, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if ({issue0, issue1, stall} !== 3'b000) begin
      fails++;
      $display("FAIL R1: got %b expected 000", {issue0, issue1, stall});
    end
    step(0, 1, OSR, 1, 1, LVR, 1, 1, 1, 0, "R1 first issue after reset");
    step(0, 1, OSR, 1, 1, LVR|OSR, 1, 1, 1, 0, "R2 read-only pair");
    step(0, 1, LVW, 1, 1, OSR, 1, 1, 0, 0, "R3 merged lv write blocks os read");
    step(0, 1, OSR, 1, 1, LVW, 1, 1, 0, 0, "R3 merged war across areas");
    step(1, 1, LVW, 1, 1, OSR, 1, 1, 1, 0, "R4 split lv write with os read");
    step(1, 1, OSW, 1, 1, LVW, 1, 1, 1, 0, "R4 split writes in both areas");
    step(1, 1, OSW, 1, 1, OSR, 1, 1, 0, 0, "R5 split os raw");
    step(1, 1, LVW, 1, 1, LVR, 1, 1, 0, 0, "R5 split lv raw");
    step(1, 1, LVW, 1, 1, LVW, 1, 1, 0, 0, "R6 split lv waw");
    step(1, 1, OSR, 1, 1, OSW, 1, 1, 0, 0, "R6 split os war");
    step(1, 1, OSR, 1, 0, OSR, 1, 1, 0, 0, "R7 no v1 no pair");
    step(1, 0, OSR, 1, 1, OSR, 1, 0, 0, 0, "R8 v0 low blocks all");
    step(1, 1, OSR, 3, 1, LVR, 1, 1, 1, 1, "R9 pair lat 3 issue");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 1, "R10 ignored while stalled");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 0, "R9 stall released");
    step(1, 1, OSR, 1, 1, LVR, 5, 1, 1, 1, "R9 slot1 longer lat 5");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 1, "R10 stall 1 of 4");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 1, "R10 stall 2 of 4");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 1, "R10 stall 3 of 4");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 0, "R9 stall ends after lat-1");
    step(1, 1, OSW, 2, 1, OSR, 7, 1, 0, 1, "R11 unpaired uses slot0 lat");
    step(1, 1, OSR, 1, 1, LVR, 1, 0, 0, 0, "R11 one stall cycle only");
    step(1, 1, OSR, 0, 1, LVR, 0, 1, 1, 0, "R9 lat 0 counts as 1");
    step(0, 0, OSR, 1, 0, OSR, 1, 0, 0, 0, "R8 idle");
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule